// File: doc/BRIEF.md
# Graceful DMA Stop Controller

This block brings the receive and transmit DMA engines of an Ethernet MAC to an orderly halt before the MAC enables are turned off. Software raises a stop request for each direction through a DMA control register. For each direction the block keeps DMA from starting a new frame and waits for any frame already in flight to finish. It then raises a sticky completion event for that direction.

A combined stopped flag goes high once both completion events are set. Software waits for that flag before it clears the MAC transmit and receive enables. To re-arm the stop, software drops the request bits and raises them again. Dropping both requests at start-up lets both DMA engines run. Each event is cleared by writing one to it, and also by a fresh request in the same direction, so an old event cannot satisfy a new stop.

Index 0 of every vector is the receive direction and index 1 is the transmit direction.

Top module: `dma_stop_ctrl`

## Requirements
- R1: After reset both run enables are 1, both completion events are 0 and the stopped flag is 0, as long as no request is high.
- R2: A request that arrives while its direction has no frame in progress sets that direction's completion event at the first clock edge that samples the request high.
- R3: A request that arrives while a frame is in progress holds the completion event at 0 for as long as the busy input stays high. The event is set at the first clock edge that samples busy low with the request still high.
- R4: A completion event stays set while its request is held and after the request is withdrawn, until it is cleared by R5 or R6.
- R5: A one on an event-clear input clears that event at the next clock edge. If the event is set at that same edge, setting wins.
- R6: A request that rises after its direction has returned to running clears any stale completion event for that direction. It then follows R2 or R3.
- R7: A run enable is 0 in every cycle in which its request is high, and stays 0 until the clock edge after the request is sampled low. With no request pending it is 1.
- R8: If a request is withdrawn while its frame is still in progress, no completion event is raised and the run enable returns to 1 after the next clock edge.
- R9: The stopped flag is 1 exactly when both completion events are 1.
- R10: The two directions are independent: requests, busy inputs and clears of one direction never change the other direction's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | NUM_DIR | Stop request level per direction (0 receive, 1 transmit) |
| evt_clr | input | NUM_DIR | Write-one-to-clear pulse for each completion event |
| frame_busy | input | NUM_DIR | Frame in progress, from each datapath |
| run_en | output | NUM_DIR | DMA may start a new frame in this direction |
| stop_evt | output | NUM_DIR | Sticky stop-complete event per direction |
| stopped | output | 1 | All directions stopped; MAC enables may be cleared |

## Verification
Completion events and the state behind them are registered, so a request, busy or clear input applied in a cycle shows up on stop_evt one clock edge later. The run enable also reacts in the same cycle to a rising request, and the stopped flag follows the events without delay. The bench drives inputs on the falling edge and compares run_en one time step later, against the model state from the previous rising edge and the present inputs. It compares the registered outputs one time step after each rising edge, once the model has taken in the same inputs.

// File: rtl/dstop_pkg.sv
package dstop_pkg;

    typedef enum logic [1:0] {
        LANE_RUN   = 2'd0,
        LANE_DRAIN = 2'd1,
        LANE_HALT  = 2'd2
    } lane_state_e;

    typedef struct packed {
        lane_state_e st;
        logic        evt;
    } lane_regs_t;

    localparam lane_regs_t LANE_RESET = '{st: LANE_RUN, evt: 1'b0};

endpackage

// File: rtl/dstop_lane.sv
module dstop_lane
    import dstop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic clr,
    input  logic busy,
    output logic run_en,
    output logic evt
);

    lane_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.evt = 1'b0;
        end
        unique case (r_q.st)
            LANE_RUN: begin
                if (req) begin
                    r_d.evt = 1'b0;            // fresh request drops a stale event
                    if (busy) begin
                        r_d.st = LANE_DRAIN;
                    end else begin
                        r_d.st  = LANE_HALT;
                        r_d.evt = 1'b1;
                    end
                end
            end
            LANE_DRAIN: begin
                if (!req) begin
                    r_d.st = LANE_RUN;         // withdrawn before frame ended
                end else if (!busy) begin
                    r_d.st  = LANE_HALT;
                    r_d.evt = 1'b1;
                end
            end
            LANE_HALT: begin
                if (!req) begin
                    r_d.st = LANE_RUN;
                end
            end
            default: begin
                r_d = LANE_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= LANE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_en = (r_q.st == LANE_RUN) && !req;
    assign evt    = r_q.evt;

endmodule

// File: rtl/dstop_combine.sv
module dstop_combine #(
    parameter int NUM_DIR = 2
) (
    input  logic [NUM_DIR-1:0] evt,
    output logic               all_done
);

    assign all_done = &evt;

endmodule

// File: rtl/dma_stop_ctrl.sv
module dma_stop_ctrl #(
    parameter int NUM_DIR = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DIR-1:0] stop_req,
    input  logic [NUM_DIR-1:0] evt_clr,
    input  logic [NUM_DIR-1:0] frame_busy,
    output logic [NUM_DIR-1:0] run_en,
    output logic [NUM_DIR-1:0] stop_evt,
    output logic               stopped
);

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_lane
        dstop_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (stop_req[g]),
            .clr    (evt_clr[g]),
            .busy   (frame_busy[g]),
            .run_en (run_en[g]),
            .evt    (stop_evt[g])
        );
    end

    dstop_combine #(.NUM_DIR(NUM_DIR)) u_comb (
        .evt      (stop_evt),
        .all_done (stopped)
    );

endmodule

// File: rtl/dstop_checker.sv
module dstop_checker #(
    parameter int NUM_DIR = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_DIR-1:0] stop_req,
    input logic [NUM_DIR-1:0] evt_clr,
    input logic [NUM_DIR-1:0] frame_busy,
    input logic [NUM_DIR-1:0] run_en,
    input logic [NUM_DIR-1:0] stop_evt,
    input logic               stopped
);

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_chk
        assert_no_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
            stop_req[g] |-> !run_en[g]);

        assert_evt_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stop_evt[g]) |-> ($past(stop_req[g]) && !$past(frame_busy[g])));

        assert_idle_req_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (run_en[g] == 1'b0 && stop_req[g] && !frame_busy[g] && !$past(stop_req[g]))
            |=> stop_evt[g]);

        assert_evt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stop_evt[g]) && !$past(evt_clr[g]) && !$past(stop_req[g])) |-> stop_evt[g]);

        assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(evt_clr[g]) && !$past(stop_req[g])) |-> !stop_evt[g]);
    end

    assert_stopped_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stopped == (&stop_evt));

endmodule

bind dma_stop_ctrl dstop_checker #(.NUM_DIR(NUM_DIR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .evt_clr    (evt_clr),
    .frame_busy (frame_busy),
    .run_en     (run_en),
    .stop_evt   (stop_evt),
    .stopped    (stopped)
);

// File: tb/sim_dma_stop_ctrl.sv
module sim_dma_stop_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req = 2'b00, clr = 2'b00, busy = 2'b00;
    logic [1:0] run_en, stop_evt;
    logic       stopped;

    int n_cmp = 0;
    int n_bad = 0;
    int mst [2];   // 0 running, 1 waiting for frame end, 2 halted
    bit mevt [2];
    bit done = 0;

    always #5 clk = ~clk;

    dma_stop_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(req), .evt_clr(clr),
        .frame_busy(busy), .run_en(run_en), .stop_evt(stop_evt), .stopped(stopped)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
        end
    endtask

    function automatic bit m_run(input int i);
        return (mst[i] == 0) && !req[i];
    endfunction

    task automatic compare_all();
        for (int i = 0; i < 2; i++) begin
            chk("R7 run_en", run_en[i], m_run(i));
            chk("R4 stop_evt", stop_evt[i], mevt[i]);
        end
        chk("R9 stopped", stopped, mevt[0] && mevt[1]);
    endtask

    task automatic model_edge();
        for (int i = 0; i < 2; i++) begin
            bit ne = mevt[i];
            if (clr[i]) ne = 0;
            if (mst[i] == 0) begin
                if (req[i]) begin
                    ne = 0;
                    if (busy[i]) mst[i] = 1;
                    else begin mst[i] = 2; ne = 1; end
                end
            end else if (mst[i] == 1) begin
                if (!req[i]) mst[i] = 0;
                else if (!busy[i]) begin mst[i] = 2; ne = 1; end
            end else begin
                if (!req[i]) mst[i] = 0;
            end
            mevt[i] = ne;
        end
    endtask

    // drive at falling edge, compare, let rising edge happen, update model, settle
    task automatic step(input logic [1:0] r, input logic [1:0] c, input logic [1:0] b);
        @(negedge clk);
        req = r; clr = c; busy = b;
        #1 compare_all();
        @(posedge clk);
        model_edge();
        #1 compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: got 1 expected 0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2; i++) begin mst[i] = 0; mevt[i] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        chk("R1 reset run_en", run_en, 2'b11);
        chk("R1 reset stop_evt", stop_evt, 2'b00);
        chk("R1 reset stopped", stopped, 0);

        // receive request on idle direction
        step(2'b01, 2'b00, 2'b00);
        chk("R2 rx idle event", stop_evt[0], 1);
        chk("R7 rx run_en low", run_en[0], 0);
        chk("R10 tx untouched", stop_evt[1], 0);

        // transmit request with frame still in flight
        step(2'b11, 2'b00, 2'b10);
        chk("R3 tx busy no event", stop_evt[1], 0);
        step(2'b11, 2'b00, 2'b10);
        step(2'b11, 2'b00, 2'b10);
        chk("R3 tx still busy", stop_evt[1], 0);
        chk("R9 not yet stopped", stopped, 0);
        step(2'b11, 2'b00, 2'b00);
        chk("R3 tx frame ended", stop_evt[1], 1);
        chk("R9 both stopped", stopped, 1);
        chk("R4 rx held", stop_evt[0], 1);

        // withdraw both: events sticky, runs resume
        step(2'b00, 2'b00, 2'b00);
        chk("R4 sticky after withdraw", stop_evt, 2'b11);
        chk("R7 run resumes", run_en, 2'b11);

        // clear receive only
        step(2'b00, 2'b01, 2'b00);
        chk("R5 rx cleared", stop_evt[0], 0);
        chk("R10 tx kept", stop_evt[1], 1);
        chk("R9 stopped drops", stopped, 0);

        // re-arm transmit while busy: stale event dropped
        step(2'b10, 2'b00, 2'b10);
        chk("R6 stale tx event cleared", stop_evt[1], 0);

        // withdraw during drain
        step(2'b00, 2'b00, 2'b10);
        chk("R8 no event on withdraw", stop_evt[1], 0);
        chk("R8 tx run resumes", run_en[1], 1);
        step(2'b00, 2'b00, 2'b00);
        chk("R8 still no event", stop_evt[1], 0);

        // set wins over a simultaneous clear
        step(2'b01, 2'b01, 2'b00);
        chk("R5 set beats clear", stop_evt[0], 1);
        step(2'b00, 2'b00, 2'b00);

        // mixed traffic against the model every cycle
        for (int k = 0; k < 2000; k++) begin
            logic [1:0] r, c, b;
            r = req; 
            for (int i = 0; i < 2; i++) begin
                if ($urandom_range(0, 7) == 0) r[i] = ~r[i];
                b[i] = ($urandom_range(0, 2) != 0);
                c[i] = ($urandom_range(0, 9) == 0);
            end
            step(r, c, b);
        end

        finish_run();
    end

endmodule